// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive side of a DMA queue engine. Software builds a chain of 32-byte descriptors in memory. Each descriptor gives a buffer address, a buffer size and a next-descriptor pointer, and carries an ownership bit. The engine walks the chain one descriptor at a time. For each descriptor it reads the descriptor and checks that it holds ownership. It then writes one incoming frame from the MAC byte stream into the buffer. Last, it writes back the stored byte count and a status word with ownership handed back to software.

When the engine completes a descriptor marked as the last in the chain, it raises an end-of-queue flag and stops. Software clears the flag by writing one to it. The engine runs again only after software re-arms the queue pointer. When no usable descriptor is present, an incoming frame is consumed and dropped, and a saturating overrun counter advances.

Software drives the block through a small register port. Memory traffic uses a single 32-bit request/acknowledge port. Frames arrive as a byte stream that carries last and error flags.

Top module: `rxq_ring_engine`

## Requirements
- R1: After reset, `mem_req` is 0, `eoq` is 0, `overrun_count` is 0 and `in_ready` is 1, so the idle engine accepts and discards bytes.
- R2: Register writes use `reg_sel` codes 0 = control, 1 = pointer low, 2 = pointer high, 3 = end-of-queue status. Fetching starts only when two conditions hold. First, the last control write had both bit 15 and bit 0 set. Second, a pointer-high write with bit 31 set arrived while the engine was idle; that write copies the pointer-low value into the start pointer. A pointer-high write with bit 31 clear arms nothing.
- R3: Descriptor fields are 32-bit words at byte offsets from the descriptor base. Offset 0 holds the buffer address and offset 8 the next pointer. At offset 12, bit 31 marks the last descriptor. At offset 20 is the status word: buffer size in bits 31:16 and the owner bit in bit 15. The engine reads offset 20, then 0, 8 and 12.
- R4: If the owner bit is clear, nothing is written. The next frame is dropped and counted as an overrun. The same descriptor's status word is then read again.
- R5: Frame bytes are packed little-endian (first byte in bits 7:0) into 32-bit words written from the buffer address upward. A final partial word is written with zero in the unused lanes.
- R6: After the data, the engine writes the stored byte count to offset 16 (upper half zero). It then writes offset 20 with the buffer size kept in bits 31:16, bit 15 cleared, bit 1 (start of frame) and bit 0 (end of frame) set.
- R7: Bytes beyond the buffer size are not written, and the count equals the size. Status bit 11 (length exceeded) and bit 8 (bad frame) are set.
- R8: If `in_err` is high on any byte of the frame, status bit 12 (CRC error) and bit 8 are set.
- R9: A frame shorter than `MIN_LEN` bytes sets status bit 4 (short frame) and bit 8.
- R10: After a descriptor that is not last, the engine follows its next pointer. After the last descriptor, `eoq` goes to 1 and no further memory access occurs until the queue is re-armed.
- R11: A status-register write with bit 0 set clears `eoq`. A write with bit 0 clear leaves it set.
- R12: A frame that arrives while the engine is idle is dropped, and `overrun_count` is incremented by one. The engine is idle when it is not armed, not enabled, or stopped at end of queue.
- R13: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 pointer low, 2 pointer high, 3 end-of-queue status |
| reg_wdata | input | 32 | Register write data |
| eoq | output | 1 | End-of-queue flag |
| overrun_count | output | CNT_W | Saturating count of dropped frames |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Receive error on this byte |
| in_ready | output | 1 | Engine accepts the byte this cycle |

## Verification
A wrong fill position or an early buffer-limit check shows up directly on the memory port. The write addresses and data of the very next frame differ from expected, so every write is compared in order as it happens. Faults in the ownership or chain state stay hidden until the next descriptor boundary. They then show at the ports in one of three ways: as an extra or missing read, as a drop reported by `overrun_count` in place of a buffer fill, or as `eoq` rising at the wrong descriptor. For that reason the bench counts reads and checks them after each arming and after the end of the chain.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // descriptor word byte offsets
  localparam logic [31:0] OFF_BUF     = 32'd0;
  localparam logic [31:0] OFF_NEXT_LO = 32'd8;
  localparam logic [31:0] OFF_NEXT_HI = 32'd12;
  localparam logic [31:0] OFF_COUNT   = 32'd16;
  localparam logic [31:0] OFF_STAT    = 32'd20;

  // status word bit positions
  localparam int B_EOF    = 0;
  localparam int B_SOF    = 1;
  localparam int B_SHORT  = 4;
  localparam int B_BAD    = 8;
  localparam int B_MAXLEN = 11;
  localparam int B_CRC    = 12;
  localparam int B_OWN    = 15;
  localparam int B_LAST   = 31;

  // register interface
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PLO  = 2'd1;
  localparam logic [1:0] SEL_PHI  = 2'd2;
  localparam logic [1:0] SEL_EOQ  = 2'd3;
  localparam int B_GO    = 15;
  localparam int B_QEN   = 0;
  localparam int B_VALID = 31;
  localparam int B_EOQ   = 0;

  // width of the size and count fields
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_NOOWN,
    ST_FILL,
    ST_CNT,
    ST_STAT
  } rxq_state_e;
endpackage

// File: rtl/rxq_regs.sv
module rxq_regs
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  input  logic        idle,
  input  logic        eoq_set,
  output logic        enable,
  output logic        armed,
  output logic [31:0] start_ptr,
  output logic        eoq
);
  logic [31:0] ptr_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      armed     <= 1'b0;
      start_ptr <= '0;
      ptr_lo    <= '0;
      eoq       <= 1'b0;
    end else begin
      if (we && sel == SEL_CTRL)
        enable <= wdata[B_GO] & wdata[B_QEN];
      if (we && sel == SEL_PLO)
        ptr_lo <= wdata;
      if (we && sel == SEL_PHI && wdata[B_VALID] && idle) begin
        start_ptr <= ptr_lo;
        armed     <= 1'b1;
      end
      if (eoq_set)
        armed <= 1'b0;
      if (we && sel == SEL_EOQ && wdata[B_EOQ])
        eoq <= 1'b0;
      if (eoq_set)
        eoq <= 1'b1;
    end
  end

  AST_ARM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(idle)); // R2
  AST_EOQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (eoq && !(we && sel == SEL_EOQ && wdata[B_EOQ])) |=> eoq); // R11
endmodule

// File: rtl/rxq_packer.sv
module rxq_packer
  import rxq_pkg::*;
#(
  parameter int MIN_LEN = 60
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic             last,
  input  logic             err,
  input  logic [LEN_W-1:0] limit,
  input  logic             wr_ack,
  output logic             pend,
  output logic [31:0]      word,
  output logic [LEN_W-1:0] off,
  output logic             done,
  output logic [LEN_W-1:0] count,
  output logic             f_trunc,
  output logic             f_crc,
  output logic             f_short
);
  localparam logic [LEN_W-1:0] SHORT_LIM = LEN_W'(MIN_LEN - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = '1;

  logic [31:0]      acc, nacc;
  logic [LEN_W-1:0] total;
  logic             flush;

  always_comb begin
    nacc = acc;
    nacc[8*count[1:0] +: 8] = data;
  end

  assign flush = (count[1:0] == 2'd3) || last || (count + 1'b1 == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      total   <= '0;
      count   <= '0;
      pend    <= 1'b0;
      word    <= '0;
      off     <= '0;
      done    <= 1'b0;
      f_trunc <= 1'b0;
      f_crc   <= 1'b0;
      f_short <= 1'b0;
    end else begin
      if (wr_ack)
        pend <= 1'b0;
      if (take) begin
        if (err)
          f_crc <= 1'b1;
        if (total != LEN_MAX)
          total <= total + 1'b1;
        if (count < limit) begin
          count <= count + 1'b1;
          if (flush) begin
            pend <= 1'b1;
            word <= nacc;
            off  <= {count[LEN_W-1:2], 2'b00};
            acc  <= '0;
          end else begin
            acc <= nacc;
          end
        end else begin
          f_trunc <= 1'b1;
        end
        if (last) begin
          done    <= 1'b1;
          f_short <= (total < SHORT_LIM);
        end
      end
    end
  end

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (pend && !wr_ack && !clr) |=> (pend && $stable(word) && $stable(off))); // R5
  AST_STORE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (take && !clr && count >= limit) |=> (count == $past(count))); // R7
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             armed,
  input  logic [31:0]      start_ptr,
  output logic             eoq_set,
  output logic             idle,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  input  logic             in_valid,
  input  logic             in_last,
  output logic             in_ready,
  output logic             pk_clr,
  output logic             pk_take,
  output logic             pk_ack,
  output logic [LEN_W-1:0] buf_size,
  input  logic             pk_pend,
  input  logic [31:0]      pk_word,
  input  logic [LEN_W-1:0] pk_off,
  input  logic             pk_done,
  input  logic [LEN_W-1:0] pk_count,
  input  logic             pk_trunc,
  input  logic             pk_crc,
  input  logic             pk_short,
  output logic [CNT_W-1:0] overrun_count
);
  localparam logic [CNT_W-1:0] OVR_MAX = '1;

  rxq_state_e  state;
  logic [1:0]  step;
  logic [31:0] cur_ptr, buf_addr, next_ptr;
  logic        last_flag, mid_frame, take, done_ack;
  logic [31:0] fetch_off, stat_word;

  always_comb begin
    case (state)
      ST_IDLE, ST_NOOWN: in_ready = 1'b1;
      ST_FILL:           in_ready = !pk_pend && !pk_done;
      default:           in_ready = 1'b0;
    endcase
  end

  always_comb begin
    case (step)
      2'd0:    fetch_off = OFF_STAT;
      2'd1:    fetch_off = OFF_BUF;
      2'd2:    fetch_off = OFF_NEXT_LO;
      default: fetch_off = OFF_NEXT_HI;
    endcase
  end

  always_comb begin
    stat_word = {buf_size, {LEN_W{1'b0}}};
    stat_word[B_EOF]    = 1'b1;
    stat_word[B_SOF]    = 1'b1;
    stat_word[B_SHORT]  = pk_short;
    stat_word[B_MAXLEN] = pk_trunc;
    stat_word[B_CRC]    = pk_crc;
    stat_word[B_BAD]    = pk_short | pk_trunc | pk_crc;
  end

  assign take     = in_valid && in_ready;
  assign pk_take  = take && (state == ST_FILL);
  assign pk_clr   = (state == ST_FETCH);
  assign pk_ack   = (state == ST_FILL) && mem_req && mem_ack;
  assign done_ack = (state == ST_STAT) && mem_req && mem_ack;
  assign eoq_set  = done_ack && last_flag;
  assign idle     = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      step          <= 2'd0;
      cur_ptr       <= '0;
      buf_addr      <= '0;
      next_ptr      <= '0;
      buf_size      <= '0;
      last_flag     <= 1'b0;
      mid_frame     <= 1'b0;
      mem_req       <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
      overrun_count <= '0;
    end else begin
      if (take)
        mid_frame <= !in_last;
      if (take && in_last && (state == ST_IDLE || state == ST_NOOWN) &&
          overrun_count != OVR_MAX)
        overrun_count <= overrun_count + 1'b1;

      case (state)
        ST_IDLE: begin
          if (enable && armed && !mid_frame && !take) begin
            cur_ptr <= start_ptr;
            step    <= 2'd0;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_req) begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              case (step)
                2'd0: begin
                  buf_size <= mem_rdata[31:16];
                  if (mem_rdata[B_OWN]) step <= 2'd1;
                  else                  state <= ST_NOOWN;
                end
                2'd1: begin buf_addr <= mem_rdata; step <= 2'd2; end
                2'd2: begin next_ptr <= mem_rdata; step <= 2'd3; end
                default: begin
                  last_flag <= mem_rdata[B_LAST];
                  state     <= ST_FILL;
                end
              endcase
            end
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_ptr + fetch_off;
          end
        end
        ST_NOOWN: begin
          if (take && in_last) begin
            step  <= 2'd0;
            state <= ST_FETCH;
          end
        end
        ST_FILL: begin
          if (mem_req) begin
            if (mem_ack) mem_req <= 1'b0;
          end else if (pk_pend) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= buf_addr + 32'(pk_off);
            mem_wdata <= pk_word;
          end else if (pk_done) begin
            state <= ST_CNT;
          end
        end
        ST_CNT: begin
          if (mem_req) begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              state   <= ST_STAT;
            end
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr + OFF_COUNT;
            mem_wdata <= {{(32-LEN_W){1'b0}}, pk_count};
          end
        end
        ST_STAT: begin
          if (mem_req) begin
            if (mem_ack) begin
              mem_req <= 1'b0;
              if (last_flag) begin
                state <= ST_IDLE;
              end else begin
                cur_ptr <= next_ptr;
                step    <= 2'd0;
                state   <= ST_FETCH;
              end
            end
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr + OFF_STAT;
            mem_wdata <= stat_word;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) &&
                               $stable(mem_wdata))); // R13
  AST_NO_WRITE_UNOWNED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NOOWN) |-> !mem_req); // R4
endmodule

// File: rtl/rxq_ring_engine.sv
module rxq_ring_engine
  import rxq_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic             eoq,
  output logic [CNT_W-1:0] overrun_count,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_err,
  output logic             in_ready
);
  logic             enable, armed, eoq_set, idle;
  logic [31:0]      start_ptr;
  logic             pk_clr, pk_take, pk_ack, pk_pend, pk_done;
  logic             pk_trunc, pk_crc, pk_short;
  logic [LEN_W-1:0] buf_size, pk_off, pk_count;
  logic [31:0]      pk_word;

  rxq_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .idle(idle), .eoq_set(eoq_set), .enable(enable), .armed(armed),
    .start_ptr(start_ptr), .eoq(eoq)
  );

  rxq_packer #(.MIN_LEN(MIN_LEN)) u_pack (
    .clk(clk), .rst(rst), .clr(pk_clr), .take(pk_take), .data(in_data),
    .last(in_last), .err(in_err), .limit(buf_size), .wr_ack(pk_ack),
    .pend(pk_pend), .word(pk_word), .off(pk_off), .done(pk_done),
    .count(pk_count), .f_trunc(pk_trunc), .f_crc(pk_crc), .f_short(pk_short)
  );

  rxq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .armed(armed), .start_ptr(start_ptr),
    .eoq_set(eoq_set), .idle(idle), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .pk_clr(pk_clr), .pk_take(pk_take), .pk_ack(pk_ack),
    .buf_size(buf_size), .pk_pend(pk_pend), .pk_word(pk_word), .pk_off(pk_off),
    .pk_done(pk_done), .pk_count(pk_count), .pk_trunc(pk_trunc),
    .pk_crc(pk_crc), .pk_short(pk_short), .overrun_count(overrun_count)
  );
endmodule

// File: tb/sim_rxq_ring_engine.sv
`timescale 1ns/1ps
module sim_rxq_ring_engine;
  localparam int MINL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        eoq;
  logic [15:0] overrun_count;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_err = 1'b0;
  logic        in_ready;

  always #2.5 clk = ~clk;

  rxq_ring_engine #(.MIN_LEN(MINL), .CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .eoq(eoq), .overrun_count(overrun_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_ready(in_ready)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] mem [0:1023];
  int          checks = 0;
  int          fails = 0;
  int          reads = 0;
  int          lat = 0;
  logic [31:0] seen_addr, seen_wdata;
  logic        seen_we;
  bit          finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // memory model and write scoreboard monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !rst) begin
      if (lat == 0) begin
        seen_addr = mem_addr; seen_wdata = mem_wdata; seen_we = mem_we;
      end
      if (lat == 2) begin
        lat = 0;
        chk("R13 request held stable", {mem_addr[30:0], mem_we},
            {seen_addr[30:0], seen_we});
        if (mem_we) chk("R13 write data held", mem_wdata, seen_wdata);
        if (mem_we) begin
          if (exp_q.size() == 0) begin
            chk("R4/R10 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " addr"}, mem_addr, e.a);
            chk({e.tag, " data"}, mem_wdata, e.d);
          end
          mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          reads++;
        end
        mem_ack = 1'b1;
      end else begin
        lat++;
      end
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input int first, input int err_at);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(first + i);
      in_last  = (i == n - 1);
      in_err   = (i == err_at);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  // scoreboard driver: expected writes of one completed descriptor
  task automatic expect_frame(input logic [31:0] desc, input logic [31:0] bufa,
                              input int size, input int n, input int first,
                              input int err_at);
    int stored;
    logic [31:0] st;
    stored = (n < size) ? n : size;
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      logic [31:0] wd;
      wd = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < stored) wd[8*b +: 8] = 8'(first + w * 4 + b);
      exp_q.push_back('{bufa + 32'(4 * w), wd, "R5 buffer word"});
    end
    exp_q.push_back('{desc + 32'd16, 32'(stored), "R6/R7 byte count"});
    st = {16'(size), 16'h0003};
    if (err_at >= 0 && err_at < n) st = st | 32'h0000_1100; // R8
    if (n > size)                  st = st | 32'h0000_0900; // R7
    if (n < MINL)                  st = st | 32'h0000_0110; // R9
    exp_q.push_back('{desc + 32'd20, st, "R6 status word"});
  endtask

  task automatic wait_drain();
    int guard;
    guard = 0;
    wait_cycles(30);
    while ((mem_req || exp_q.size() != 0) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R6 all expected writes seen", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  task automatic put_desc(input logic [31:0] d, input logic [31:0] bufa,
                          input logic [31:0] nxt, input logic last,
                          input int size, input logic own);
    mem[d[11:2]]       = bufa;
    mem[d[11:2] + 2]   = nxt;
    mem[d[11:2] + 3]   = {last, 31'd0};
    mem[d[11:2] + 4]   = '0;
    mem[d[11:2] + 5]   = {16'(size), own, 15'd0};
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(1);

    // R1 reset state
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 eoq after reset", {31'd0, eoq}, 32'd0);
    chk("R1 overrun after reset", {16'd0, overrun_count}, 32'd0);
    chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R12 frame while unarmed is dropped
    send_frame(3, 8'h50, -1);
    wait_drain();
    chk("R12 drop while idle", {16'd0, overrun_count}, 32'd1);

    put_desc(32'h100, 32'h400, 32'h120, 1'b0, 64, 1'b1);
    put_desc(32'h120, 32'h600, 32'h140, 1'b0, 6,  1'b1);
    put_desc(32'h140, 32'h800, 32'h000, 1'b1, 64, 1'b1);

    // R2 arming without valid bit, and enable missing queue bit
    reg_write(2'd1, 32'h100);
    reg_write(2'd2, 32'h0000_0000);
    reg_write(2'd0, 32'h0000_8001);
    wait_cycles(30);
    chk("R2 no fetch without valid bit", 32'(reads), 32'd0);
    reg_write(2'd0, 32'h0000_8000);
    reg_write(2'd2, 32'h8000_0000);
    wait_cycles(30);
    chk("R2 no fetch without queue enable", 32'(reads), 32'd0);
    reg_write(2'd0, 32'h0000_8001);
    wait_cycles(40);
    chk("R3 four descriptor reads", 32'(reads), 32'd4);

    // frame 1: plain frame with a partial last word
    expect_frame(32'h100, 32'h400, 64, 10, 8'h10, -1);
    send_frame(10, 8'h10, -1);
    wait_drain();
    chk("R10 chain continues eoq low", {31'd0, eoq}, 32'd0);

    // frame 2: truncated at size 6 with an error byte
    expect_frame(32'h120, 32'h600, 6, 9, 8'h30, 2);
    send_frame(9, 8'h30, 2);
    wait_drain();

    // frame 3: short frame in last descriptor
    expect_frame(32'h140, 32'h800, 64, 5, 8'h70, -1);
    send_frame(5, 8'h70, -1);
    wait_drain();
    chk("R10 eoq after last descriptor", {31'd0, eoq}, 32'd1);
    chk("R10 reads over three descriptors", 32'(reads), 32'd12);
    wait_cycles(40);
    chk("R10 no access after end", 32'(reads), 32'd12);

    // R12 frame while stopped at end of queue
    send_frame(4, 8'h90, -1);
    wait_drain();
    chk("R12 drop at end of queue", {16'd0, overrun_count}, 32'd2);

    // R11 write-one-to-clear
    reg_write(2'd3, 32'h0000_0000);
    wait_cycles(2);
    chk("R11 zero write keeps eoq", {31'd0, eoq}, 32'd1);
    reg_write(2'd3, 32'h0000_0001);
    wait_cycles(2);
    chk("R11 one write clears eoq", {31'd0, eoq}, 32'd0);

    // R4 descriptor not owned
    put_desc(32'h180, 32'hA00, 32'h000, 1'b1, 64, 1'b0);
    reg_write(2'd1, 32'h180);
    reg_write(2'd2, 32'h8000_0000);
    wait_cycles(30);
    chk("R4 only status read when not owned", 32'(reads), 32'd13);
    send_frame(6, 8'hA0, -1);
    wait_drain();
    chk("R4 drop counted", {16'd0, overrun_count}, 32'd3);
    chk("R4 status re-read", 32'(reads), 32'd14);
    mem[(32'h180 >> 2) + 5] = {16'd64, 1'b1, 15'd0};
    send_frame(6, 8'hB0, -1);
    wait_drain();
    chk("R4 frame in wait state dropped", {16'd0, overrun_count}, 32'd4);
    expect_frame(32'h180, 32'hA00, 64, 8, 8'hC0, -1);
    send_frame(8, 8'hC0, -1);
    wait_drain();
    chk("R4 owned after re-read eoq", {31'd0, eoq}, 32'd1);
    chk("R12 overrun unchanged on fill", {16'd0, overrun_count}, 32'd4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule